// File: doc/BRIEF.md
# Segment Register Load Validator

This block decides whether a 16-bit selector may be loaded into a data segment register or into the stack segment register. A request carries the selector, the register class and the current privilege level. The block splits the selector into its requestor privilege, table bit and index. It screens out the null selector and entries past the end of the chosen table without touching memory.

For any other selector it asks a table-fetch agent for the 8-byte descriptor over a simple request/response port. It then applies type, privilege and presence rules to the descriptor's rights byte. It answers with a one-cycle result that is one of two kinds. An acceptance carries the descriptor to cache. A fault carries a vector number and an error code. When several rules fail, only the first one in a fixed priority order is reported.

A new request is taken only while the block is idle, and software-facing state is left to the surrounding core.

Top module: `seg_load_checker`

## Requirements
- R1: After reset `done` and `desc_req_valid` are 0, and they stay 0 until a request is made.
- R2: A selector with index 0 and table bit (bit 2) 0 is null. Its requestor privilege bits are ignored. For a data register, a null selector is accepted with `ok`=1, `unusable`=1, `desc_out`=0, and no descriptor is fetched.
- R3: A null selector loaded into the stack register faults with vector 13 and error code 0, and no descriptor is fetched.
- R4: If index*8+7 is greater than the chosen table's limit, the load faults with vector 13 and no descriptor is fetched. The local limit is used when bit 2 is 1, and the global limit when it is 0. When index*8+7 equals the limit, the fetch goes ahead, with `desc_req_local` equal to bit 2 and `desc_req_index` equal to bits 15:3.
- R5: The rights byte is descriptor bits 47:40. In that byte, bit 4 set means code/data, bit 3 set means executable, and bit 1 means writable for data or readable for code. A data register load faults with vector 13 unless the descriptor is code/data and either not executable or readable.
- R6: A data register load faults with vector 13 when max(CPL, RPL) is numerically greater than the descriptor privilege (rights bits 6:5).
- R7: A stack load faults with vector 13 unless the descriptor is code/data, not executable and writable, and both the descriptor privilege and the RPL equal the CPL.
- R8: A clear present bit (rights bit 7) faults with vector 11 for a data register and vector 12 for the stack register.
- R9: Faults are prioritised in this order: null, limit, type, privilege, present. Only the first failing rule is reported.
- R10: When every rule passes, `ok`=1, `unusable`=0 and `desc_out` equals the fetched descriptor. Exactly one of `ok` and `fault` is set with each `done`.
- R11: Except for the null stack case, a fault's error code is the selector with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Load request, taken when idle |
| req_sel | input | 16 | Selector to load |
| req_stack | input | 1 | 1 = stack register, 0 = data register |
| req_cpl | input | 2 | Current privilege level |
| gdt_limit | input | 16 | Byte limit of the global table |
| ldt_limit | input | 16 | Byte limit of the local table |
| desc_req_valid | output | 1 | One-cycle descriptor fetch request |
| desc_req_local | output | 1 | Fetch from local table |
| desc_req_index | output | 13 | Descriptor index to fetch |
| desc_rsp_valid | input | 1 | Fetched descriptor is valid |
| desc_rsp_data | input | 64 | Fetched descriptor |
| done | output | 1 | One-cycle result strobe |
| ok | output | 1 | Load accepted |
| unusable | output | 1 | Accepted null, register unusable |
| fault | output | 1 | Load rejected |
| fault_vec | output | 8 | Fault vector number |
| err_code | output | 16 | Fault error code |
| desc_out | output | 64 | Descriptor to cache |

## Verification
The bench drives selectors that sit exactly on a table limit and one entry past it, in both tables. A design with an off-by-one compare, or with the limit inputs swapped, would fetch or reject the wrong entries. It sends descriptors that fail two or three rules at once. A design with the check order wrong would report the not-present vector where the protection vector is due. Null selectors go in with nonzero requestor bits and with the local table bit set, to catch a null test that looks at the wrong bits. The stack rules are tested one at a time, for read-only data, executable code and each kind of privilege mismatch, because a design that reused the data rules would accept these loads.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } seg_chk_state_e;

   function automatic logic [1:0] max_pl(input logic [1:0] a, input logic [1:0] b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
   parameter int SEL_W       = 16,
   parameter int LIM_W       = 16,
   parameter bit CHECK_LIMIT = 1'b1
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [LIM_W-1:0] gdt_limit,
   input  logic [LIM_W-1:0] ldt_limit,
   output logic [1:0]       rpl,
   output logic             ti,
   output logic [SEL_W-4:0] index,
   output logic             is_null,
   output logic             over_limit,
   output logic [SEL_W-1:0] err_sel
);
   localparam int IDX_W = SEL_W - 3;
   localparam int CMP_W = ((SEL_W > LIM_W) ? SEL_W : LIM_W) + 1;

   if (SEL_W < 4) begin : g_bad_sel
      $error("seg_sel_decode: SEL_W must be at least 4");
   end
   if (LIM_W < 3) begin : g_bad_lim
      $error("seg_sel_decode: LIM_W must be at least 3");
   end

   logic [CMP_W-1:0] last_byte;
   logic [CMP_W-1:0] lim_ext;

   assign rpl     = sel[1:0];
   assign ti      = sel[2];
   assign index   = sel[SEL_W-1:3];
   assign is_null = (index == {IDX_W{1'b0}}) && !ti;
   assign err_sel = {sel[SEL_W-1:2], 2'b00};

   assign last_byte = {{(CMP_W-SEL_W){1'b0}}, index, 3'b111};
   assign lim_ext   = {{(CMP_W-LIM_W){1'b0}}, (ti ? ldt_limit : gdt_limit)};

   if (CHECK_LIMIT) begin : g_limit
      assign over_limit = last_byte > lim_ext;
   end else begin : g_no_limit
      assign over_limit = 1'b0;
   end
endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check #(
   parameter int VEC_W  = 8,
   parameter int GP_VEC = 13,
   parameter int NP_VEC = 11,
   parameter int SS_VEC = 12
) (
   input  logic             is_stack,
   input  logic [1:0]       cpl,
   input  logic [1:0]       rpl,
   input  logic             present,
   input  logic [1:0]       dpl,
   input  logic             code_data,
   input  logic             exec,
   input  logic             wr_rd,
   output logic             bad,
   output logic [VEC_W-1:0] vec
);
   import seg_chk_pkg::*;

   if (VEC_W < 4) begin : g_bad_vec
      $error("seg_rights_check: VEC_W too small for vector numbers");
   end

   logic [1:0] epl;
   logic       type_bad;
   logic       priv_bad;

   assign epl = max_pl(cpl, rpl);

   always_comb begin
      if (is_stack) begin
         type_bad = !code_data || exec || !wr_rd;
         priv_bad = (dpl != cpl) || (rpl != cpl);
      end else begin
         type_bad = !code_data || (exec && !wr_rd);
         priv_bad = epl > dpl;
      end
   end

   always_comb begin
      bad = 1'b1;
      vec = VEC_W'(GP_VEC);
      if (type_bad || priv_bad) begin
         vec = VEC_W'(GP_VEC);
      end else if (!present) begin
         vec = is_stack ? VEC_W'(SS_VEC) : VEC_W'(NP_VEC);
      end else begin
         bad = 1'b0;
      end
   end
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker #(
   parameter int SEL_W       = 16,
   parameter int LIM_W       = 16,
   parameter int DESC_W      = 64,
   parameter int AR_LSB      = 40,
   parameter int VEC_W       = 8,
   parameter int GP_VEC      = 13,
   parameter int NP_VEC      = 11,
   parameter int SS_VEC      = 12,
   parameter bit CHECK_LIMIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic              req_stack,
   input  logic [1:0]        req_cpl,
   input  logic [LIM_W-1:0]  gdt_limit,
   input  logic [LIM_W-1:0]  ldt_limit,
   output logic              desc_req_valid,
   output logic              desc_req_local,
   output logic [SEL_W-4:0]  desc_req_index,
   input  logic              desc_rsp_valid,
   input  logic [DESC_W-1:0] desc_rsp_data,
   output logic              done,
   output logic              ok,
   output logic              unusable,
   output logic              fault,
   output logic [VEC_W-1:0]  fault_vec,
   output logic [SEL_W-1:0]  err_code,
   output logic [DESC_W-1:0] desc_out
);
   import seg_chk_pkg::*;

   if (AR_LSB + 8 > DESC_W) begin : g_bad_ar
      $error("seg_load_checker: rights byte lies outside the descriptor");
   end

   seg_chk_state_e   st;
   logic [SEL_W-1:0] lat_sel;
   logic             lat_stack;
   logic [1:0]       lat_cpl;

   logic [SEL_W-1:0] dec_sel;
   logic [1:0]       dec_rpl;
   logic             dec_ti;
   logic [SEL_W-4:0] dec_index;
   logic             dec_null;
   logic             dec_over;
   logic [SEL_W-1:0] dec_err;

   logic [7:0]       rights;
   logic             chk_bad;
   logic [VEC_W-1:0] chk_vec;

   assign dec_sel = (st == ST_IDLE) ? req_sel : lat_sel;

   seg_sel_decode #(
      .SEL_W(SEL_W), .LIM_W(LIM_W), .CHECK_LIMIT(CHECK_LIMIT)
   ) u_decode (
      .sel(dec_sel), .gdt_limit(gdt_limit), .ldt_limit(ldt_limit),
      .rpl(dec_rpl), .ti(dec_ti), .index(dec_index),
      .is_null(dec_null), .over_limit(dec_over), .err_sel(dec_err)
   );

   assign rights = desc_rsp_data[AR_LSB +: 8];

   seg_rights_check #(
      .VEC_W(VEC_W), .GP_VEC(GP_VEC), .NP_VEC(NP_VEC), .SS_VEC(SS_VEC)
   ) u_rights (
      .is_stack(lat_stack), .cpl(lat_cpl), .rpl(dec_rpl),
      .present(rights[7]), .dpl(rights[6:5]), .code_data(rights[4]),
      .exec(rights[3]), .wr_rd(rights[1]),
      .bad(chk_bad), .vec(chk_vec)
   );

   assign desc_req_valid = (st == ST_ISSUE);
   assign desc_req_local = dec_ti;
   assign desc_req_index = dec_index;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         lat_sel   <= '0;
         lat_stack <= 1'b0;
         lat_cpl   <= 2'd0;
         done      <= 1'b0;
         ok        <= 1'b0;
         unusable  <= 1'b0;
         fault     <= 1'b0;
         fault_vec <= '0;
         err_code  <= '0;
         desc_out  <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  lat_sel   <= req_sel;
                  lat_stack <= req_stack;
                  lat_cpl   <= req_cpl;
                  if (dec_null) begin
                     done      <= 1'b1;
                     ok        <= !req_stack;
                     unusable  <= !req_stack;
                     fault     <= req_stack;
                     fault_vec <= req_stack ? VEC_W'(GP_VEC) : '0;
                     err_code  <= '0;
                     desc_out  <= '0;
                  end else if (dec_over) begin
                     done      <= 1'b1;
                     ok        <= 1'b0;
                     unusable  <= 1'b0;
                     fault     <= 1'b1;
                     fault_vec <= VEC_W'(GP_VEC);
                     err_code  <= dec_err;
                     desc_out  <= '0;
                  end else begin
                     st <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: st <= ST_WAIT;
            ST_WAIT: begin
               if (desc_rsp_valid) begin
                  st        <= ST_IDLE;
                  done      <= 1'b1;
                  ok        <= !chk_bad;
                  unusable  <= 1'b0;
                  fault     <= chk_bad;
                  fault_vec <= chk_bad ? chk_vec : '0;
                  err_code  <= chk_bad ? dec_err : '0;
                  desc_out  <= chk_bad ? '0 : desc_rsp_data;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/seg_load_checker_sva.sv
module seg_load_checker_sva #(
   parameter int SEL_W  = 16,
   parameter int DESC_W = 64,
   parameter int VEC_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              desc_req_valid,
   input logic              desc_rsp_valid,
   input logic [DESC_W-1:0] desc_rsp_data,
   input logic              done,
   input logic              ok,
   input logic              unusable,
   input logic              fault,
   input logic [VEC_W-1:0]  fault_vec,
   input logic [SEL_W-1:0]  err_code,
   input logic [DESC_W-1:0] desc_out
);
   logic [DESC_W-1:0] seen_desc;
   logic              fetched;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_desc <= '0;
         fetched   <= 1'b0;
      end else begin
         if (desc_rsp_valid) seen_desc <= desc_rsp_data;
         if (desc_req_valid) fetched <= 1'b1;
         else if (done) fetched <= 1'b0;
      end
   end

   assert_fetch_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      desc_req_valid |=> !desc_req_valid);

   assert_null_no_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && unusable) |-> (ok && !fault && !fetched && desc_out == '0));

   assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ok != fault));

   assert_cached_desc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ok && !unusable) |-> (fetched && desc_out == seen_desc));

   assert_err_low_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (err_code[1:0] == 2'b00));

   assert_vec_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> (fault_vec == VEC_W'(11) || fault_vec == VEC_W'(12)
                           || fault_vec == VEC_W'(13)));
endmodule

bind seg_load_checker seg_load_checker_sva #(
   .SEL_W(SEL_W), .DESC_W(DESC_W), .VEC_W(VEC_W)
) u_sva (
   .clk(clk), .rst_n(rst_n), .desc_req_valid(desc_req_valid),
   .desc_rsp_valid(desc_rsp_valid), .desc_rsp_data(desc_rsp_data),
   .done(done), .ok(ok), .unusable(unusable), .fault(fault),
   .fault_vec(fault_vec), .err_code(err_code), .desc_out(desc_out)
);

// File: tb/seg_load_checker_bench.sv
module seg_load_checker_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_sel = '0;
   logic        req_stack = 1'b0;
   logic [1:0]  req_cpl = '0;
   logic [15:0] gdt_limit = 16'h00FF;
   logic [15:0] ldt_limit = 16'h003F;
   logic        desc_req_valid;
   logic        desc_req_local;
   logic [12:0] desc_req_index;
   logic        desc_rsp_valid = 1'b0;
   logic [63:0] desc_rsp_data = '0;
   logic        done, ok, unusable, fault;
   logic [7:0]  fault_vec;
   logic [15:0] err_code;
   logic [63:0] desc_out;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   logic        g_ok, g_unus, g_fault, g_fetched, g_local;
   logic [7:0]  g_vec;
   logic [15:0] g_err;
   logic [12:0] g_idx;
   logic [63:0] g_desc;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_load_checker u_seg_load_checker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_stack(req_stack), .req_cpl(req_cpl), .gdt_limit(gdt_limit),
      .ldt_limit(ldt_limit), .desc_req_valid(desc_req_valid),
      .desc_req_local(desc_req_local), .desc_req_index(desc_req_index),
      .desc_rsp_valid(desc_rsp_valid), .desc_rsp_data(desc_rsp_data),
      .done(done), .ok(ok), .unusable(unusable), .fault(fault),
      .fault_vec(fault_vec), .err_code(err_code), .desc_out(desc_out)
   );

   function automatic logic [63:0] mk_desc(input logic [7:0] ar);
      return {8'hAB, 8'h4F, ar, 24'h345678, 16'h9ABC};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_load(input logic [15:0] sel, input logic stk,
                          input logic [1:0] cpl, input logic [63:0] d);
      g_fetched = 1'b0;
      g_local = 1'b0;
      g_idx = '0;
      @(negedge clk);
      req_valid = 1'b1; req_sel = sel; req_stack = stk; req_cpl = cpl;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (desc_req_valid) begin
            g_fetched = 1'b1; g_local = desc_req_local; g_idx = desc_req_index;
            desc_rsp_valid = 1'b1; desc_rsp_data = d;
         end
         if (done) break;
         @(negedge clk);
      end
      g_ok = ok; g_unus = unusable; g_fault = fault && done;
      g_vec = fault_vec; g_err = err_code; g_desc = desc_out;
      if (!done) g_ok = 1'bx;
      desc_rsp_valid = 1'b0;
   endtask

   task automatic expect_fault(input string tag, input logic [7:0] vec,
                               input logic [15:0] err);
      chk({tag, " fault"}, {63'd0, g_fault}, 64'd1);
      chk({tag, " vector"}, {56'd0, g_vec}, {56'd0, vec});
      chk({tag, " error code"}, {48'd0, g_err}, {48'd0, err});
   endtask

   task automatic expect_accept(input string tag, input logic [63:0] d);
      chk({tag, " ok"}, {62'd0, g_ok, g_fault}, 64'd2);
      chk({tag, " unusable"}, {63'd0, g_unus}, 64'd0);
      chk({tag, " desc_out"}, g_desc, d);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk("R1 done after reset", {63'd0, done}, 64'd0);
      chk("R1 fetch after reset", {63'd0, desc_req_valid}, 64'd0);
   endtask

   task automatic t_null;
      do_load(16'h0003, 1'b0, 2'd3, mk_desc(8'h92));
      chk("R2 null data ok/unusable", {61'd0, g_ok, g_unus, g_fault}, 64'd6);
      chk("R2 null data desc_out", g_desc, 64'd0);
      chk("R2 null data no fetch", {63'd0, g_fetched}, 64'd0);
      do_load(16'h0002, 1'b1, 2'd2, mk_desc(8'hD2));
      expect_fault("R3 null stack", 8'd13, 16'h0000);
      chk("R3 null stack no fetch", {63'd0, g_fetched}, 64'd0);
      do_load(16'h0004, 1'b0, 2'd0, mk_desc(8'h92));
      chk("R2 local index 0 not null", {63'd0, g_fetched}, 64'd1);
      expect_accept("R2 local index 0", mk_desc(8'h92));
   endtask

   task automatic t_limit;
      do_load(16'h0101, 1'b0, 2'd0, mk_desc(8'h92));
      expect_fault("R4 global past limit", 8'd13, 16'h0100);
      chk("R4 global past limit no fetch", {63'd0, g_fetched}, 64'd0);
      do_load(16'h00F8, 1'b0, 2'd0, mk_desc(8'h92));
      chk("R4 global at limit fetched", {63'd0, g_fetched}, 64'd1);
      chk("R4 global fetch table", {63'd0, g_local}, 64'd0);
      chk("R4 global fetch index", {51'd0, g_idx}, 64'd31);
      expect_accept("R10 global at limit", mk_desc(8'h92));
      do_load(16'h0044, 1'b0, 2'd0, mk_desc(8'h92));
      expect_fault("R4 local past limit", 8'd13, 16'h0044);
      chk("R4 local past limit no fetch", {63'd0, g_fetched}, 64'd0);
      do_load(16'h003C, 1'b0, 2'd0, mk_desc(8'h92));
      chk("R4 local fetch table", {63'd0, g_local}, 64'd1);
      chk("R4 local fetch index", {51'd0, g_idx}, 64'd7);
      expect_accept("R10 local at limit", mk_desc(8'h92));
   endtask

   task automatic t_data_type;
      do_load(16'h0017, 1'b0, 2'd0, mk_desc(8'h82));
      expect_fault("R5 system descriptor", 8'd13, 16'h0014);
      do_load(16'h0010, 1'b0, 2'd0, mk_desc(8'h98));
      expect_fault("R5 execute-only code", 8'd13, 16'h0010);
      do_load(16'h0010, 1'b0, 2'd0, mk_desc(8'h9A));
      expect_accept("R5 readable code", mk_desc(8'h9A));
      do_load(16'h0010, 1'b0, 2'd0, mk_desc(8'h90));
      expect_accept("R5 read-only data", mk_desc(8'h90));
   endtask

   task automatic t_data_priv;
      do_load(16'h0013, 1'b0, 2'd0, mk_desc(8'hD2));
      expect_fault("R6 rpl 3 above dpl 2", 8'd13, 16'h0010);
      do_load(16'h0010, 1'b0, 2'd3, mk_desc(8'hD2));
      expect_fault("R6 cpl 3 above dpl 2", 8'd13, 16'h0010);
      do_load(16'h0010, 1'b0, 2'd3, mk_desc(8'hF2));
      expect_accept("R6 cpl 3 dpl 3", mk_desc(8'hF2));
      do_load(16'h0011, 1'b0, 2'd1, mk_desc(8'hB2));
      expect_accept("R6 equal levels 1", mk_desc(8'hB2));
   endtask

   task automatic t_stack;
      do_load(16'h0010, 1'b1, 2'd0, mk_desc(8'h92));
      expect_accept("R7 writable stack", mk_desc(8'h92));
      do_load(16'h0010, 1'b1, 2'd0, mk_desc(8'h90));
      expect_fault("R7 read-only stack", 8'd13, 16'h0010);
      do_load(16'h0010, 1'b1, 2'd0, mk_desc(8'h9A));
      expect_fault("R7 code as stack", 8'd13, 16'h0010);
      do_load(16'h0011, 1'b1, 2'd0, mk_desc(8'h92));
      expect_fault("R7 rpl differs", 8'd13, 16'h0010);
      do_load(16'h0010, 1'b1, 2'd0, mk_desc(8'hF2));
      expect_fault("R7 dpl differs", 8'd13, 16'h0010);
      do_load(16'h0013, 1'b1, 2'd3, mk_desc(8'hF2));
      expect_accept("R7 stack at level 3", mk_desc(8'hF2));
   endtask

   task automatic t_present;
      do_load(16'h0018, 1'b0, 2'd0, mk_desc(8'h12));
      expect_fault("R8 data not present", 8'd11, 16'h0018);
      do_load(16'h0018, 1'b1, 2'd0, mk_desc(8'h12));
      expect_fault("R8 stack not present", 8'd12, 16'h0018);
   endtask

   task automatic t_priority;
      do_load(16'h0020, 1'b0, 2'd0, mk_desc(8'h02));
      expect_fault("R9 type before present", 8'd13, 16'h0020);
      do_load(16'h0020, 1'b0, 2'd3, mk_desc(8'h52));
      expect_fault("R9 privilege before present", 8'd13, 16'h0020);
      do_load(16'h0021, 1'b1, 2'd0, mk_desc(8'h12));
      expect_fault("R9 stack privilege before present", 8'd13, 16'h0020);
      do_load(16'h0102, 1'b0, 2'd0, mk_desc(8'h02));
      expect_fault("R9 limit before type", 8'd13, 16'h0100);
      do_load(16'h0000, 1'b1, 2'd0, mk_desc(8'h12));
      expect_fault("R9 null before all", 8'd13, 16'h0000);
      do_load(16'h0027, 1'b1, 2'd3, mk_desc(8'h02));
      expect_fault("R11 local selector error code", 8'd13, 16'h0024);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_reset;
      t_null;
      t_limit;
      t_data_type;
      t_data_priv;
      t_stack;
      t_present;
      t_priority;
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule